// File: doc/BRIEF.md
# Binary SIMD Pixel-Processor Array

This block is a two-dimensional grid of identical one-bit processing elements. They are driven in lockstep by one broadcast instruction. Each element holds fourteen binary registers. The top register also serves as the element's activity flag. The only Boolean operations are OR and NOT, so every other function is built as a short sequence of broadcast steps. Each element also receives its own one-bit comparator result as an input, and one instruction copies it into a register. The comparator bit is the only way data from outside the grid enters the registers.

Three paths carry results out. A single-bit read returns one register of one addressed element. A masked read returns the OR of one register across every element whose row and column are both selected by two bit masks. A word read gathers eight consecutive registers of one element into a byte. It takes one register per clock and is run by a small state machine with three states:

- **IDLE**: waits for a request. A request moves it to SHIFT.
- **SHIFT**: captures one bit per cycle. After the eighth bit it moves to DONE.
- **DONE**: presents the byte for one cycle, then returns to IDLE.

Top module: `bitplane_simd_array`

## Requirements
- R1: While reset is held and after it is released, all registers of all elements are 0, and `rd_valid`, `word_valid` and `word_busy` are 0.
- R2: Operation codes are 00 copy (dest = A), 01 OR (dest = A or B), 10 NOT (dest = not A) and 11 load comparator (dest = the element's own `cmp_in` bit, at index row*COLS+col). A source index of 14 or 15 reads as 0.
- R3: With `instr_valid` high, all elements write their destination together on the next rising edge. With `instr_valid` low, no register changes.
- R4: With `instr_flag_en` high, an element whose register 13 (its activity flag) is 0 does not write. Elements whose flag is 1 write normally.
- R5: A destination index of 14 or 15 writes nothing in any element.
- R6: A read request with `rd_or_mode` at 0 gives `rd_valid` high on the next cycle. `rd_bit` then equals register `rd_reg` of the element at (`rd_row`, `rd_col`).
- R7: With `rd_or_mode` at 1, `rd_bit` is the OR of register `rd_reg` over all elements whose row bit in `rd_row_mask` and column bit in `rd_col_mask` are both 1. Bit i of a mask selects row or column i. A mask of all zeros gives 0.
- R8: A read requested in the same cycle as an instruction returns the register values from before that instruction's write.
- R9: An accepted word request makes `word_valid` high for exactly one cycle, on the eighth rising edge after the accepting edge. Bit k of `word_data` is register `word_base`+k of the latched element, taken from the state just before the (k+1)-th edge after acceptance. Indices above 13 give 0.
- R10: `word_busy` is high from the accepting edge until the `word_valid` cycle ends. Word requests made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Broadcast instruction present |
| instr_dest | input | IDXW | Destination register index |
| instr_src_a | input | IDXW | First source register index |
| instr_src_b | input | IDXW | Second source register index |
| instr_op | input | 2 | Operation code |
| instr_flag_en | input | 1 | Gate writes by the activity flag |
| cmp_in | input | ROWS*COLS | Per-element comparator bits |
| rd_req | input | 1 | Read request |
| rd_or_mode | input | 1 | 0 single element, 1 masked OR |
| rd_row | input | RW | Row address for a single read |
| rd_col | input | CW | Column address for a single read |
| rd_row_mask | input | ROWS | Row selection mask for the OR read |
| rd_col_mask | input | COLS | Column selection mask for the OR read |
| rd_reg | input | IDXW | Register index to read |
| rd_valid | output | 1 | Read result valid |
| rd_bit | output | 1 | Read result |
| word_req | input | 1 | Word read request |
| word_row | input | RW | Word element row |
| word_col | input | CW | Word element column |
| word_base | input | IDXW | First register of the word |
| word_busy | output | 1 | Word gather in progress |
| word_valid | output | 1 | Word result valid |
| word_data | output | WBITS | Gathered word |

## Verification
Two things can happen in the same cycle: a broadcast write, and a read of the register that write targets. A read then returns the old value. A word gather that is already running picks up new values in the bits it has not yet captured. The bench provokes both overlaps. It issues an instruction and a single or masked read on the same edge, and it issues instructions while a word gather is in flight. The bench keeps its own mirror of every register. On each edge it computes the expected read result from the mirror before it applies the write, so any forwarding of new data, or any missing update, shows up at `rd_bit` or `word_data`.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
    typedef enum logic [1:0] {
        OP_COPY  = 2'b00,
        OP_OR    = 2'b01,
        OP_NOT   = 2'b10,
        OP_LDCMP = 2'b11
    } bsa_op_e;

    typedef enum logic [1:0] {
        W_IDLE,
        W_SHIFT,
        W_DONE
    } word_state_e;
endpackage

// File: rtl/bsa_pe.sv
module bsa_pe #(
    parameter int NREG = 14,
    parameter int IDXW = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid,
    input  logic [IDXW-1:0]  instr_dest,
    input  logic [IDXW-1:0]  instr_src_a,
    input  logic [IDXW-1:0]  instr_src_b,
    input  logic [1:0]       instr_op,
    input  logic             instr_flag_en,
    input  logic             cmp,
    output logic [NREG-1:0]  q
);
    import bsa_pkg::*;

    localparam int FLAG = NREG - 1;

    logic a_bit, b_bit, res, we, dest_ok;

    always_comb begin
        a_bit   = 1'b0;
        b_bit   = 1'b0;
        dest_ok = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (instr_src_a == IDXW'(i)) a_bit = q[i];
            if (instr_src_b == IDXW'(i)) b_bit = q[i];
            if (instr_dest == IDXW'(i)) dest_ok = 1'b1;
        end
        unique case (bsa_op_e'(instr_op))
            OP_COPY:  res = a_bit;
            OP_OR:    res = a_bit | b_bit;
            OP_NOT:   res = ~a_bit;
            OP_LDCMP: res = cmp;
            default:  res = 1'b0;
        endcase
        we = instr_valid && dest_ok && (!instr_flag_en || q[FLAG]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            for (int i = 0; i < NREG; i++) begin
                if (instr_dest == IDXW'(i)) q[i] <= res;
            end
        end
    end

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(q));
    // R4
    flag_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_flag_en && !q[FLAG]) |=> $stable(q));
    // R5
    dest_range_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_dest >= IDXW'(NREG)) |=> $stable(q));
    // R2
    ldcmp_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !instr_flag_en && bsa_op_e'(instr_op) == OP_LDCMP
         && instr_dest == '0) |=> (q[0] == $past(cmp)));
endmodule

// File: rtl/bsa_readout.sv
module bsa_readout #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int NREG = 14,
    parameter int IDXW = 4,
    parameter int RW   = 2,
    parameter int CW   = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [ROWS*COLS-1:0][NREG-1:0]  pe_q,
    input  logic                            rd_req,
    input  logic                            rd_or_mode,
    input  logic [RW-1:0]                   rd_row,
    input  logic [CW-1:0]                   rd_col,
    input  logic [ROWS-1:0]                 rd_row_mask,
    input  logic [COLS-1:0]                 rd_col_mask,
    input  logic [IDXW-1:0]                 rd_reg,
    output logic                            rd_valid,
    output logic                            rd_bit
);
    logic single_bit, or_bit;

    always_comb begin
        single_bit = 1'b0;
        or_bit     = 1'b0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                for (int i = 0; i < NREG; i++) begin
                    if (rd_reg == IDXW'(i)) begin
                        if (rd_row == RW'(r) && rd_col == CW'(c))
                            single_bit = pe_q[r*COLS+c][i];
                        if (rd_row_mask[r] && rd_col_mask[c])
                            or_bit = or_bit | pe_q[r*COLS+c][i];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_bit   <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            rd_bit   <= rd_req && (rd_or_mode ? or_bit : single_bit);
        end
    end

    // R6
    rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);
    // R6
    rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);
    // R7
    zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_or_mode && (rd_row_mask == '0 || rd_col_mask == '0)) |=> !rd_bit);
endmodule

// File: rtl/bsa_word_fsm.sv
module bsa_word_fsm #(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int NREG  = 14,
    parameter int IDXW  = 4,
    parameter int RW    = 2,
    parameter int CW    = 2,
    parameter int WBITS = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [ROWS*COLS-1:0][NREG-1:0]  pe_q,
    input  logic                            word_req,
    input  logic [RW-1:0]                   word_row,
    input  logic [CW-1:0]                   word_col,
    input  logic [IDXW-1:0]                 word_base,
    output logic                            word_busy,
    output logic                            word_valid,
    output logic [WBITS-1:0]                word_data
);
    import bsa_pkg::*;

    localparam int KW = (WBITS > 1) ? $clog2(WBITS) : 1;

    word_state_e state_q, state_d;
    logic [KW-1:0]    cnt_q;
    logic [RW-1:0]    row_q;
    logic [CW-1:0]    col_q;
    logic [IDXW-1:0]  base_q;
    logic [WBITS-1:0] shreg_q;
    logic             cur_bit;
    logic             last_bit;

    assign last_bit = (cnt_q == KW'(WBITS-1));

    always_comb begin
        cur_bit = 1'b0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                for (int i = 0; i < NREG; i++) begin
                    if (row_q == RW'(r) && col_q == CW'(c) &&
                        (int'(base_q) + int'(cnt_q)) == i)
                        cur_bit = pe_q[r*COLS+c][i];
                end
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:  if (word_req) state_d = W_SHIFT;
            W_SHIFT: if (last_bit) state_d = W_DONE;
            W_DONE:  state_d = W_IDLE;
            default: state_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= W_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            row_q   <= '0;
            col_q   <= '0;
            base_q  <= '0;
            shreg_q <= '0;
        end else if (state_q == W_IDLE && word_req) begin
            cnt_q  <= '0;
            row_q  <= word_row;
            col_q  <= word_col;
            base_q <= word_base;
        end else if (state_q == W_SHIFT) begin
            shreg_q[cnt_q] <= cur_bit;
            cnt_q          <= cnt_q + KW'(1);
        end
    end

    always_comb begin
        word_busy  = (state_q != W_IDLE);
        word_valid = (state_q == W_DONE);
        word_data  = shreg_q;
    end

    // R9
    word_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);
    // R10
    word_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (word_busy && !word_valid) |=> ($stable(base_q) && $stable(row_q) && $stable(col_q)));
    // R10
    word_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!word_busy && word_req) |=> (word_busy && !word_valid));
endmodule

// File: rtl/bitplane_simd_array.sv
module bitplane_simd_array #(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int NREG  = 14,
    parameter int IDXW  = 4,
    parameter int WBITS = 8,
    localparam int NPE  = ROWS * COLS,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [IDXW-1:0]   instr_dest,
    input  logic [IDXW-1:0]   instr_src_a,
    input  logic [IDXW-1:0]   instr_src_b,
    input  logic [1:0]        instr_op,
    input  logic              instr_flag_en,
    input  logic [NPE-1:0]    cmp_in,
    input  logic              rd_req,
    input  logic              rd_or_mode,
    input  logic [RW-1:0]     rd_row,
    input  logic [CW-1:0]     rd_col,
    input  logic [ROWS-1:0]   rd_row_mask,
    input  logic [COLS-1:0]   rd_col_mask,
    input  logic [IDXW-1:0]   rd_reg,
    output logic              rd_valid,
    output logic              rd_bit,
    input  logic              word_req,
    input  logic [RW-1:0]     word_row,
    input  logic [CW-1:0]     word_col,
    input  logic [IDXW-1:0]   word_base,
    output logic              word_busy,
    output logic              word_valid,
    output logic [WBITS-1:0]  word_data
);
    logic [NPE-1:0][NREG-1:0] pe_q;

    for (genvar g = 0; g < NPE; g++) begin : g_pe
        bsa_pe #(.NREG(NREG), .IDXW(IDXW)) u_pe (
            .clk           (clk),
            .rst           (rst),
            .instr_valid   (instr_valid),
            .instr_dest    (instr_dest),
            .instr_src_a   (instr_src_a),
            .instr_src_b   (instr_src_b),
            .instr_op      (instr_op),
            .instr_flag_en (instr_flag_en),
            .cmp           (cmp_in[g]),
            .q             (pe_q[g])
        );
    end

    bsa_readout #(
        .ROWS(ROWS), .COLS(COLS), .NREG(NREG), .IDXW(IDXW), .RW(RW), .CW(CW)
    ) u_readout (
        .clk         (clk),
        .rst         (rst),
        .pe_q        (pe_q),
        .rd_req      (rd_req),
        .rd_or_mode  (rd_or_mode),
        .rd_row      (rd_row),
        .rd_col      (rd_col),
        .rd_row_mask (rd_row_mask),
        .rd_col_mask (rd_col_mask),
        .rd_reg      (rd_reg),
        .rd_valid    (rd_valid),
        .rd_bit      (rd_bit)
    );

    bsa_word_fsm #(
        .ROWS(ROWS), .COLS(COLS), .NREG(NREG), .IDXW(IDXW), .RW(RW), .CW(CW),
        .WBITS(WBITS)
    ) u_word (
        .clk        (clk),
        .rst        (rst),
        .pe_q       (pe_q),
        .word_req   (word_req),
        .word_row   (word_row),
        .word_col   (word_col),
        .word_base  (word_base),
        .word_busy  (word_busy),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!rd_valid && !word_valid && !word_busy));
endmodule

// File: tb/bitplane_simd_array_tb.sv
module bitplane_simd_array_tb_top;
    localparam int ROWS = 4, COLS = 4, NREG = 14, IDXW = 4, WBITS = 8;
    localparam int NPE = ROWS * COLS;
    localparam int RW = 2, CW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic instr_valid = 0, instr_flag_en = 0;
    logic [IDXW-1:0] instr_dest = 0, instr_src_a = 0, instr_src_b = 0;
    logic [1:0] instr_op = 0;
    logic [NPE-1:0] cmp_in = 0;
    logic rd_req = 0, rd_or_mode = 0;
    logic [RW-1:0] rd_row = 0, word_row = 0;
    logic [CW-1:0] rd_col = 0, word_col = 0;
    logic [ROWS-1:0] rd_row_mask = 0;
    logic [COLS-1:0] rd_col_mask = 0;
    logic [IDXW-1:0] rd_reg = 0, word_base = 0;
    logic word_req = 0;
    logic rd_valid, rd_bit, word_busy, word_valid;
    logic [WBITS-1:0] word_data;

    int checks = 0, failures = 0;
    string ctx = "RND";

    always #10 clk = ~clk;

    bitplane_simd_array #(.ROWS(ROWS), .COLS(COLS), .NREG(NREG), .IDXW(IDXW),
                          .WBITS(WBITS)) dut_i (.*);

    // bench mirror of the array
    logic [NREG-1:0] m [ROWS][COLS];
    logic e_rv = 0, e_rb = 0, e_mode = 0, e_wv = 0, m_busy = 0;
    int m_k = 0, w_r = 0, w_c = 0, w_b = 0;
    logic [WBITS-1:0] m_acc = 0;

    function automatic logic mbit(int r, int c, int idx);
        if (idx < NREG) return m[r][c][idx];
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) m[r][c] = '0;
            e_rv = 0; e_rb = 0; e_wv = 0; m_busy = 0; m_k = 0;
        end else begin
            e_rv = rd_req; e_mode = rd_or_mode; e_rb = 0;
            if (rd_req) begin
                if (rd_or_mode) begin
                    for (int r = 0; r < ROWS; r++)
                        for (int c = 0; c < COLS; c++)
                            if (rd_row_mask[r] && rd_col_mask[c])
                                e_rb = e_rb | mbit(r, c, int'(rd_reg));
                end else e_rb = mbit(int'(rd_row), int'(rd_col), int'(rd_reg));
            end
            e_wv = 0;
            if (!m_busy) begin
                if (word_req) begin
                    m_busy = 1; m_k = 0;
                    w_r = int'(word_row); w_c = int'(word_col); w_b = int'(word_base);
                end
            end else if (m_k < WBITS) begin
                m_acc[m_k] = mbit(w_r, w_c, w_b + m_k);
                m_k++;
                if (m_k == WBITS) e_wv = 1;
            end else m_busy = 0;
            if (instr_valid) begin
                for (int r = 0; r < ROWS; r++)
                    for (int c = 0; c < COLS; c++) begin
                        logic a, b, v;
                        a = mbit(r, c, int'(instr_src_a));
                        b = mbit(r, c, int'(instr_src_b));
                        case (instr_op)
                            2'b00: v = a;
                            2'b01: v = a | b;
                            2'b10: v = ~a;
                            default: v = cmp_in[r*COLS+c];
                        endcase
                        if (int'(instr_dest) < NREG && (!instr_flag_en || m[r][c][NREG-1]))
                            m[r][c][instr_dest] = v;
                    end
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s (%s) act=%0h exp=%0h at %0t", req, ctx, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R6", 32'(rd_valid), 32'(e_rv));
            if (e_rv) chk(e_mode ? "R7" : "R6", 32'(rd_bit), 32'(e_rb));
            chk("R10", 32'(word_busy), 32'(m_busy));
            chk("R9", 32'(word_valid), 32'(e_wv));
            if (e_wv) chk("R9", 32'(word_data), 32'(m_acc));
        end
    end

    task automatic cyc(); @(negedge clk); #1; endtask
    task automatic clear();
        instr_valid = 0; instr_flag_en = 0; rd_req = 0; word_req = 0;
    endtask
    task automatic issue(int d, int a, int b, int op, bit fe);
        instr_valid = 1; instr_dest = IDXW'(d); instr_src_a = IDXW'(a);
        instr_src_b = IDXW'(b); instr_op = 2'(op); instr_flag_en = fe;
    endtask
    task automatic rd1(int r, int c, int g);
        rd_req = 1; rd_or_mode = 0; rd_row = RW'(r); rd_col = CW'(c); rd_reg = IDXW'(g);
    endtask
    task automatic rdor(int rm, int cm, int g);
        rd_req = 1; rd_or_mode = 1; rd_row_mask = ROWS'(rm); rd_col_mask = COLS'(cm);
        rd_reg = IDXW'(g);
    endtask
    task automatic read_all(int g);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin rd1(r, c, g); cyc(); end
        clear(); cyc();
    endtask
    task automatic word(int r, int c, int b);
        word_req = 1; word_row = RW'(r); word_col = CW'(c); word_base = IDXW'(b);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) cyc();
        // R1: outputs quiet during reset
        chk("R1", 32'({rd_valid, word_valid, word_busy}), 0);
        rst = 0; cyc();
        ctx = "R1"; read_all(0); read_all(13);
        ctx = "R2";
        cmp_in = 16'hA5C3; issue(0, 0, 0, 3, 0); cyc(); clear(); cyc();
        read_all(0);
        issue(1, 0, 0, 2, 0); cyc(); issue(2, 0, 1, 1, 0); cyc();
        issue(3, 15, 0, 0, 0); cyc(); issue(4, 2, 0, 0, 0); cyc(); clear(); cyc();
        read_all(1); read_all(2); read_all(3); read_all(4);
        ctx = "R3";
        issue(1, 2, 0, 0, 0); instr_valid = 0; cyc(); clear(); cyc(); read_all(1);
        ctx = "R4";
        cmp_in = 16'h0F31; issue(13, 0, 0, 3, 0); cyc();
        issue(5, 15, 0, 2, 1); cyc(); clear(); cyc(); read_all(5);
        ctx = "R5";
        issue(14, 15, 0, 2, 0); cyc(); issue(15, 15, 0, 2, 0); cyc(); clear(); cyc();
        for (int g = 0; g < NREG; g++) begin rd1(3, 2, g); cyc(); end
        clear(); cyc();
        ctx = "R7";
        rdor(0, 15, 2); cyc(); rdor(15, 0, 2); cyc(); rdor(15, 15, 5); cyc();
        rdor(1, 1, 0); cyc(); rdor(8, 8, 5); cyc(); rdor(4, 2, 1); cyc(); clear(); cyc();
        ctx = "R8";
        issue(0, 0, 0, 2, 0); rd1(0, 0, 0); cyc();
        issue(0, 0, 0, 2, 0); rdor(15, 15, 0); cyc(); clear(); cyc(); read_all(0);
        ctx = "R9";
        word(1, 2, 0); cyc(); clear(); repeat (10) cyc();
        word(3, 3, 8); cyc(); clear(); repeat (10) cyc();
        ctx = "R10";
        word(0, 1, 0); cyc(); word(2, 2, 6); repeat (12) cyc(); clear(); repeat (3) cyc();
        ctx = "R9 overlap";
        word(2, 1, 0); cyc(); clear();
        for (int k = 0; k < 8; k++) begin issue(k, k, 0, 2, 0); cyc(); end
        clear(); repeat (4) cyc();
        ctx = "RND";
        for (int n = 0; n < 3000; n++) begin
            clear();
            cmp_in = NPE'($urandom);
            if ($urandom % 4 != 0)
                issue($urandom % 16, $urandom % 16, $urandom % 16, $urandom % 4,
                      ($urandom % 4) == 0);
            if ($urandom % 2 == 0) begin
                if ($urandom % 2 == 0) rd1($urandom % 4, $urandom % 4, $urandom % 16);
                else rdor($urandom % 16, $urandom % 16, $urandom % 16);
            end
            if ($urandom % 8 == 0) word($urandom % 4, $urandom % 4, $urandom % 16);
            cyc();
        end
        clear(); repeat (12) cyc();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule